// File: doc/BRIEF.md
# Calibrated Bank Temperature Converter

This block converts a bank's raw thermal-sensor readings into millidegrees Celsius and returns the hottest one. A bank has up to four slots. Each slot carries a raw ADC code and the index of the physical sensor it reads. Each sensor has its own calibration offset. Three further calibration values are shared across the bank: a gain-error correction, a slope correction and a reference temperature.

A start strobe captures all inputs. The block then computes a scale factor once for that run, using two integer divisions on a shared serial divider. It then walks the active slots one per cycle. Each slot is converted in signed 32-bit fixed point with three fraction bits. A reading above 200 °C is treated as bogus and replaced with zero. The bank maximum is published together with a single-cycle done pulse.

Top module: `tcal_bank_max`

## Requirements
- R1: Only bits [11:0] of each 16-bit raw slot code take part in the conversion; bits [15:12] have no effect on the result.
- R2: The scale is `(1627604160 / (165 + slope)) / (10000 + gain)`, with each quotient truncated; slope is a signed 7-bit value (−63..63) and gain is unsigned 10-bit.
- R3: A slot converts to `degc*500 − ((scale * (code − offset − 3350)) >>> 3)` in signed 32-bit arithmetic, where offset is the 9-bit calibration offset of the sensor named by that slot's 3-bit index (slot k's index at bits [3k+2:3k], sensor s's offset at bits [9s+8:9s]).
- R4: A converted value greater than 200000 is replaced by 0 before the maximum; exactly 200000 is kept.
- R5: The result is the maximum over the first N slots (slot k's code at bits [16k+15:16k]); N is the 3-bit slot count clamped to 4; slots at or beyond N have no effect; N = 0 yields −2147483648.
- R6: Done is high for exactly one cycle per accepted start; the result changes only in that cycle and holds until the next done.
- R7: A start while a run is in progress is ignored; the running conversion uses the inputs captured at its own start, and no extra done follows.
- R8: After reset done is low and the result reads 0.
- R9: A slot whose sensor index is 5 or more uses the offset of sensor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a conversion run (ignored while busy) |
| slot_cnt_i | input | 3 | Number of active slots, clamped to 4 |
| raw_i | input | 64 | Four 16-bit raw codes, slot 0 in the low bits |
| sel_i | input | 12 | Four 3-bit sensor indices, slot 0 in the low bits |
| offs_i | input | 45 | Five 9-bit per-sensor offsets, sensor 0 in the low bits |
| gain_i | input | 10 | Gain-error correction |
| slope_i | input | 7 | Signed slope correction |
| degc_i | input | 6 | Reference temperature in half-degree units of 500 m°C |
| max_o | output | 32 | Signed bank maximum in m°C |
| done_o | output | 1 | One-cycle result strobe |

## Verification
A corrupted divider remainder or quotient bit shows up as a wrong scale. That error affects every slot of the run, so the bench's comparison of the result catches it at the done pulse, roughly seventy cycles after start. A wrong slot counter or offset select leaves most runs intact and only moves the maximum when the affected slot would have won. For that reason, directed cases place the hottest value in the last active slot and just past the clamp. Capture-register faults caused by a start during a run show up at the next done, either as the second run's answer or as an extra done pulse.

// File: rtl/tcal_pkg.sv
package tcal_pkg;

    localparam int DW        = 32;
    localparam int RAW_W     = 16;
    localparam int CODE_W    = 12;
    localparam int SLOTS     = 4;
    localparam int NSENS     = 5;
    localparam int OFFS_W    = 9;
    localparam int GAIN_W    = 10;
    localparam int SLOPE_W   = 7;
    localparam int DEGC_W    = 6;
    localparam int FRAC_BITS = 3;

    localparam int SEL_W  = $clog2(NSENS);
    localparam int CNT_W  = $clog2(SLOTS + 1);
    localparam int SIDX_W = $clog2(SLOTS);

    localparam int CODE_MASK = (1 << CODE_W) - 1;

    localparam logic [DW-1:0]        SCALE_SEED = 32'd203450520 << FRAC_BITS;
    localparam logic signed [DW-1:0] SLOPE_BASE = 32'sd165;
    localparam logic signed [DW-1:0] GAIN_BASE  = 32'sd10000;
    localparam logic signed [DW-1:0] OFFS_BIAS  = 32'sd3350;
    localparam logic signed [DW-1:0] DEGC_MUL   = 32'sd500;
    localparam logic signed [DW-1:0] CEIL_MC    = 32'sd200000;
    localparam logic signed [DW-1:0] FLOOR_MC   = {1'b1, {(DW-1){1'b0}}};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV_SLOPE,
        ST_DIV_GAIN,
        ST_SCAN
    } tcal_state_e;

    typedef struct packed {
        logic [GAIN_W-1:0]         gain;
        logic signed [SLOPE_W-1:0] slope;
        logic [DEGC_W-1:0]         degc;
    } tcal_cal_t;

    function automatic logic signed [DW-1:0] drop_bogus(input logic signed [DW-1:0] v);
        return (v > CEIL_MC) ? '0 : v;
    endfunction

    function automatic logic signed [DW-1:0] smax(input logic signed [DW-1:0] a,
                                                  input logic signed [DW-1:0] b);
        return (b > a) ? b : a;
    endfunction

    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] c);
        return (c > CNT_W'(SLOTS)) ? CNT_W'(SLOTS) : c;
    endfunction

endpackage

// File: rtl/tcal_divider.sv
module tcal_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quot_o,
    output logic         done_o
);
    localparam int CW = $clog2(W);

    logic [W:0]    rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvd_q;
    logic [W-1:0]  dvs_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          done_q;

    logic [W:0] rem_sh;
    logic [W:0] trial;
    logic       fits;

    always_comb begin
        rem_sh = {rem_q[W-1:0], quo_q[W-1]};
        trial  = rem_sh - {1'b0, dvs_q};
        fits   = ~trial[W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvd_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go_i) begin
                rem_q <= '0;
                quo_q <= dividend_i;
                dvd_q <= dividend_i;
                dvs_q <= divisor_i;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? trial : rem_sh;
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(W - 1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign quot_o = quo_q;
    assign done_o = done_q;

    // R2
    quot_exact_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ((64'(quo_q) * 64'(dvs_q) <= 64'(dvd_q)) &&
                    (64'(dvd_q) < (64'(quo_q) + 64'd1) * 64'(dvs_q))));

    // R2
    nonzero_den_chk: assert property (@(posedge clk) disable iff (rst)
        go_i |-> (divisor_i != '0));

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        go_i |-> !run_q);

endmodule

// File: rtl/tcal_conv.sv
module tcal_conv
    import tcal_pkg::*;
(
    input  logic [RAW_W-1:0]     raw_i,
    input  logic [OFFS_W-1:0]    offs_i,
    input  logic [DEGC_W-1:0]    degc_i,
    input  logic signed [DW-1:0] scale_i,
    output logic signed [DW-1:0] mc_o
);
    logic signed [DW-1:0] code;
    logic signed [DW-1:0] offs;
    logic signed [DW-1:0] delta;
    logic signed [DW-1:0] prod;
    logic signed [DW-1:0] scaled;
    logic signed [DW-1:0] base;
    logic signed [DW-1:0] value;

    always_comb begin
        code   = DW'(raw_i & RAW_W'(CODE_MASK));
        offs   = DW'(offs_i);
        delta  = code - offs - OFFS_BIAS;
        prod   = scale_i * delta;
        scaled = prod >>> FRAC_BITS;
        base   = DW'(degc_i) * DEGC_MUL;
        value  = base - scaled;
        mc_o   = drop_bogus(value);
    end

endmodule

// File: rtl/tcal_bank_max.sv
module tcal_bank_max
    import tcal_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic [2:0]                slot_cnt_i,
    input  logic [63:0]               raw_i,
    input  logic [11:0]               sel_i,
    input  logic [44:0]               offs_i,
    input  logic [9:0]                gain_i,
    input  logic signed [6:0]         slope_i,
    input  logic [5:0]                degc_i,
    output logic signed [31:0]        max_o,
    output logic                      done_o
);
    logic [RAW_W-1:0]  raw_w  [SLOTS];
    logic [SEL_W-1:0]  sel_w  [SLOTS];
    logic [OFFS_W-1:0] offs_w [NSENS];

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_slot
            assign raw_w[g] = raw_i[g*RAW_W +: RAW_W];
            assign sel_w[g] = sel_i[g*SEL_W +: SEL_W];
        end
        for (g = 0; g < NSENS; g++) begin : g_sens
            assign offs_w[g] = offs_i[g*OFFS_W +: OFFS_W];
        end
    endgenerate

    tcal_state_e          state_q;
    tcal_cal_t            cal_q;
    logic [RAW_W-1:0]     raw_q  [SLOTS];
    logic [SEL_W-1:0]     sel_q  [SLOTS];
    logic [OFFS_W-1:0]    offs_q [NSENS];
    logic [CNT_W-1:0]     n_q;
    logic [CNT_W-1:0]     idx_q;
    logic signed [DW-1:0] scale_q;
    logic signed [DW-1:0] acc_q;
    logic signed [DW-1:0] max_q;
    logic                 go_q;
    logic                 done_q;

    logic [DW-1:0]        div_num;
    logic [DW-1:0]        div_den;
    logic [DW-1:0]        div_quot;
    logic                 div_done;

    logic signed [DW-1:0] slope_ext;
    logic [SIDX_W-1:0]    slot;
    logic [SEL_W-1:0]     slot_sel;
    logic [OFFS_W-1:0]    slot_offs;
    logic signed [DW-1:0] slot_mc;

    always_comb begin
        slope_ext = {{(DW-SLOPE_W){cal_q.slope[SLOPE_W-1]}}, cal_q.slope};
        if (state_q == ST_DIV_GAIN) begin
            div_num = div_quot;
            div_den = GAIN_BASE + DW'(cal_q.gain);
        end else begin
            div_num = SCALE_SEED;
            div_den = SLOPE_BASE + slope_ext;
        end
    end

    tcal_divider #(.W(DW)) i_div (
        .clk        (clk),
        .rst        (rst),
        .go_i       (go_q),
        .dividend_i (div_num),
        .divisor_i  (div_den),
        .quot_o     (div_quot),
        .done_o     (div_done)
    );

    always_comb begin
        slot      = idx_q[SIDX_W-1:0];
        slot_sel  = sel_q[slot];
        slot_offs = (slot_sel < SEL_W'(NSENS)) ? offs_q[slot_sel] : offs_q[0];
    end

    tcal_conv i_conv (
        .raw_i   (raw_q[slot]),
        .offs_i  (slot_offs),
        .degc_i  (cal_q.degc),
        .scale_i (scale_q),
        .mc_o    (slot_mc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cal_q   <= '0;
            n_q     <= '0;
            idx_q   <= '0;
            scale_q <= '0;
            acc_q   <= FLOOR_MC;
            max_q   <= '0;
            go_q    <= 1'b0;
            done_q  <= 1'b0;
            for (int i = 0; i < SLOTS; i++) begin
                raw_q[i] <= '0;
                sel_q[i] <= '0;
            end
            for (int i = 0; i < NSENS; i++) begin
                offs_q[i] <= '0;
            end
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cal_q.gain  <= gain_i;
                        cal_q.slope <= slope_i;
                        cal_q.degc  <= degc_i;
                        n_q         <= clamp_cnt(slot_cnt_i);
                        for (int i = 0; i < SLOTS; i++) begin
                            raw_q[i] <= raw_w[i];
                            sel_q[i] <= sel_w[i];
                        end
                        for (int i = 0; i < NSENS; i++) begin
                            offs_q[i] <= offs_w[i];
                        end
                        go_q    <= 1'b1;
                        state_q <= ST_DIV_SLOPE;
                    end
                end
                ST_DIV_SLOPE: begin
                    if (div_done) begin
                        go_q    <= 1'b1;
                        state_q <= ST_DIV_GAIN;
                    end
                end
                ST_DIV_GAIN: begin
                    if (div_done) begin
                        scale_q <= div_quot;
                        idx_q   <= '0;
                        acc_q   <= FLOOR_MC;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (idx_q < n_q) begin
                        acc_q <= smax(acc_q, slot_mc);
                        idx_q <= idx_q + 1'b1;
                    end else begin
                        max_q   <= acc_q;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign max_o  = max_q;
    assign done_o = done_q;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(max_q));

    // R4
    ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        max_q <= CEIL_MC);

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start_i) |=> ($stable(n_q) && $stable(cal_q)));

    // R5
    scan_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN) |-> (idx_q <= n_q && n_q <= CNT_W'(SLOTS)));

    // R4
    slot_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN) |-> (slot_mc <= CEIL_MC));

endmodule

// File: tb/test_tcal_bank_max.sv
module test_tcal_bank_max;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start_i = 1'b0;
    logic [2:0]         slot_cnt_i = '0;
    logic [63:0]        raw_i = '0;
    logic [11:0]        sel_i = '0;
    logic [44:0]        offs_i = '0;
    logic [9:0]         gain_i = '0;
    logic signed [6:0]  slope_i = '0;
    logic [5:0]         degc_i = '0;
    logic signed [31:0] max_o;
    logic               done_o;

    tcal_bank_max i_tcal_bank_max (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .slot_cnt_i (slot_cnt_i),
        .raw_i      (raw_i),
        .sel_i      (sel_i),
        .offs_i     (offs_i),
        .gain_i     (gain_i),
        .slope_i    (slope_i),
        .degc_i     (degc_i),
        .max_o      (max_o),
        .done_o     (done_o)
    );

    always #10 clk = ~clk;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    int raw_a [4];
    int sel_a [4];
    int offs_a [5];
    int gain, slope, degc, cnt;

    task automatic check(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int ref_conv(input int raw, input int offs);
        int s;
        int t;
        int v;
        s = 1627604160;
        s = s / (165 + slope);
        s = s / (10000 + gain);
        t = s * ((raw & 'hfff) - offs - 3350);
        t = t >>> 3;
        v = degc * 500 - t;
        return (v > 200000) ? 0 : v;
    endfunction

    function automatic int exp_max();
        int n;
        int m;
        int s;
        int v;
        n = (cnt > 4) ? 4 : cnt;
        m = 32'h8000_0000;
        for (int i = 0; i < n; i++) begin
            s = (sel_a[i] < 5) ? sel_a[i] : 0;
            v = ref_conv(raw_a[i], offs_a[s]);
            if (v > m) m = v;
        end
        return m;
    endfunction

    task automatic drive();
        for (int i = 0; i < 4; i++) begin
            raw_i[i*16 +: 16] = 16'(raw_a[i]);
            sel_i[i*3 +: 3]   = 3'(sel_a[i]);
        end
        for (int i = 0; i < 5; i++) offs_i[i*9 +: 9] = 9'(offs_a[i]);
        gain_i     = 10'(gain);
        slope_i    = 7'(slope);
        degc_i     = 6'(degc);
        slot_cnt_i = 3'(cnt);
    endtask

    task automatic set_defaults();
        gain = 512; slope = 0; degc = 40; cnt = 4;
        for (int i = 0; i < 5; i++) offs_a[i] = 260;
        for (int i = 0; i < 4; i++) begin
            raw_a[i] = 3000 + 100 * i;
            sel_a[i] = i;
        end
    endtask

    task automatic wait_done(output int got, output bit seen);
        int k;
        k = 0;
        while (!done_o && k < 400) begin
            @(negedge clk);
            k++;
        end
        seen = done_o;
        got  = max_o;
    endtask

    task automatic run(output int got, output bit seen);
        @(negedge clk);
        drive();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(got, seen);
    endtask

    task automatic run_check(input string req);
        int got;
        int exp;
        bit seen;
        exp = exp_max();
        run(got, seen);
        check(seen, {req, " done seen"}, int'(seen), 1);
        check(got == exp, req, got, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            total++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int got;
        int ref_a;
        int pulses;
        bit seen;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        // R8
        check(done_o == 1'b0, "R8 done after reset", int'(done_o), 0);
        check(max_o == 0, "R8 result after reset", max_o, 0);
        rst = 1'b0;
        @(negedge clk);

        // R2 R3: default calibration
        set_defaults();
        run_check("R2/R3 defaults");

        // R6: pulse width and hold
        @(negedge clk);
        check(done_o == 1'b0, "R6 done single cycle", int'(done_o), 0);
        ref_a = exp_max();
        repeat (10) @(negedge clk);
        check(max_o == ref_a, "R6 result holds", max_o, ref_a);

        // R4: low code gives bogus high temperature
        set_defaults();
        raw_a[0] = 0; cnt = 1;
        run_check("R4 bogus replaced");
        raw_a[1] = 0; raw_a[2] = 200; raw_a[3] = 100; cnt = 4;
        run_check("R4 all bogus");

        // R1: high raw bits ignored
        set_defaults();
        ref_a = exp_max();
        for (int i = 0; i < 4; i++) raw_a[i] = raw_a[i] | 32'hF000;
        run(got, seen);
        check(got == ref_a, "R1 high bits ignored", got, ref_a);

        // R5: hottest slot outside count has no effect
        set_defaults();
        raw_a[2] = 2200; raw_a[3] = 2100; cnt = 2;
        run_check("R5 slots beyond count");
        cnt = 4;
        run_check("R5 hottest in last slot");
        cnt = 7;
        run_check("R5 count clamped");
        cnt = 0;
        run(got, seen);
        check(got == 32'h8000_0000, "R5 zero count", got, 32'h8000_0000);

        // R9: out-of-range index uses sensor 0
        set_defaults();
        offs_a[0] = 100; offs_a[3] = 500; sel_a[3] = 7; raw_a[3] = 2300;
        run_check("R9 index fallback");

        // R2: extreme slope and gain
        set_defaults();
        slope = -63; gain = 1023;
        run_check("R2 negative slope");
        slope = 63; gain = 0; degc = 63;
        run_check("R2 positive slope");

        // R7: start during run ignored
        set_defaults();
        ref_a = exp_max();
        @(negedge clk);
        drive();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        gain = 0; slope = -50; cnt = 1;
        for (int i = 0; i < 4; i++) raw_a[i] = 2500;
        drive();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(got, seen);
        check(got == ref_a, "R7 start ignored while busy", got, ref_a);
        pulses = 0;
        repeat (150) begin
            @(negedge clk);
            if (done_o) pulses++;
        end
        check(pulses == 0, "R7 no extra done", pulses, 0);

        // R3 R5: random
        for (int n = 0; n < 40; n++) begin
            gain  = int'($urandom_range(0, 1023));
            slope = int'($urandom_range(0, 126)) - 63;
            degc  = int'($urandom_range(0, 63));
            cnt   = int'($urandom_range(1, 4));
            for (int i = 0; i < 5; i++) offs_a[i] = int'($urandom_range(0, 511));
            for (int i = 0; i < 4; i++) begin
                raw_a[i] = (n % 3 == 0) ? int'($urandom_range(0, 65535))
                                        : int'($urandom_range(1800, 4095));
                sel_a[i] = int'($urandom_range(0, 4));
            end
            run_check("R3/R5 random");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule